// File: doc/BRIEF.md
# Pixel Unpacker with Palette Lookup

The block takes 16-bit words from display memory and splits each one into pixels at one of five colour depths, most significant bits first. Each pixel is turned into a 12-bit display colour with 4 bits each for red, green and blue. At 1, 2 and 4 bpp in colour mode the pixel value indexes three 16-entry, 4-bit tables, one per channel. At 8 bpp it is split into three narrower indices, one per table. In monochrome mode a fourth table turns the pixel into a gray level. At 16 bpp the tables are bypassed, and the colour is cut straight from the word's 5-6-5 fields.

Memory words come in over a valid/ready handshake, and pixels leave over another one. A small write port lets the CPU side load any table entry at any time. Depth and mode are captured together with each word, so a setting only takes effect from the next word accepted.

Top module: `pix_lut_top`

## Requirements
- R1: After reset `pix_valid_o` is 0, `word_ready_o` is 1, and every table entry reads as 0.
- R2: `bpp_sel_i` selects the depth: 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp, 4 to 7 = 16 bpp. A word yields 16, 8, 4, 2 or 1 pixels, taken from bit 15 downward, and no other pixels are produced.
- R3: In colour mode (`mono_i` = 0) at 1, 2 and 4 bpp, the pixel zero-extended to 4 bits indexes all three tables. `pix_color_o` is {red[11:8], green[7:4], blue[3:0]}.
- R4: In monochrome mode (`mono_i` = 1) at 1, 2 and 4 bpp, the zero-extended pixel indexes the gray table, and the gray level is repeated in all three 4-bit fields. At 8 and 16 bpp, `mono_i` has no effect.
- R5: At 8 bpp, pixel bits 7:5 index the red table, bits 4:2 index the green table and bits 1:0 index the blue table, each zero-extended to 4 bits.
- R6: At 16 bpp no table is read. The output is {pixel[15:12], pixel[10:7], pixel[4:1]}.
- R7: When `tbl_we_i` is high, entry `tbl_addr_i` of table `tbl_sel_i` (0 red, 1 green, 2 blue, 3 gray) takes `tbl_data_i` at the clock edge. Every pixel unpacked after that edge sees the new value.
- R8: From an empty pipeline, the first pixel of an accepted word is valid after the second rising edge following acceptance. With `pix_ready_i` held high, the remaining pixels of the word follow on consecutive cycles.
- R9: While `pix_valid_o` is 1 and `pix_ready_i` is 0, `pix_valid_o` stays 1 and `pix_color_o` holds its value.
- R10: Depth and mode are sampled when a word is accepted. Changing them while that word is being unpacked does not change its pixels.
- R11: `word_ready_o` stays 0 while the held word still has pixels that are not yet unpacked, so a word offered during that time is neither taken nor lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bpp_sel_i | input | 3 | Depth code, captured with each word |
| mono_i | input | 1 | Monochrome mode, captured with each word |
| word_valid_i | input | 1 | Memory word offered |
| word_data_i | input | 16 | Memory word |
| word_ready_o | output | 1 | Word accepted at this edge if offered |
| pix_valid_o | output | 1 | Pixel colour valid |
| pix_ready_i | input | 1 | Consumer takes the pixel |
| pix_color_o | output | 12 | Colour {red, green, blue}, 4 bits each |
| tbl_we_i | input | 1 | Table write enable |
| tbl_sel_i | input | 2 | Table select: 0 red, 1 green, 2 blue, 3 gray |
| tbl_addr_i | input | 4 | Table entry |
| tbl_data_i | input | 4 | Value written |

## Verification
A wrong remaining-pixel count or shift register shows up within one word. The pixel stream would gain or lose pixels against the number implied by the depth, or take bits from the wrong position, and this shows on the first mismatching pixel. A stale captured depth or mode would mis-decode the whole of the held word even though the live inputs look right, so the bench changes those inputs while a word is stalled. A broken output register under back-pressure would show as a changed colour, or a dropped valid, during a stall held several cycles.

// File: rtl/pix_lut_pkg.sv
package pix_lut_pkg;
  typedef enum logic [2:0] {
    BPP1  = 3'd0,
    BPP2  = 3'd1,
    BPP4  = 3'd2,
    BPP8  = 3'd3,
    BPP16 = 3'd4
  } bpp_e;

  localparam int unsigned NUM_TBL  = 4;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned TBL_RED  = 0;
  localparam int unsigned TBL_GRN  = 1;
  localparam int unsigned TBL_BLU  = 2;
  localparam int unsigned TBL_GRAY = 3;
endpackage

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_lut_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned COMP_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                word_valid_i,
  input  logic [WORD_W-1:0]   word_data_i,
  input  logic [2:0]          bpp_i,
  input  logic                mono_i,
  output logic                word_ready_o,
  input  logic                adv_i,
  output logic                pix_valid_o,
  output logic [7:0]          pix_idx_o,
  output logic [3*COMP_W-1:0] pix_direct_o,
  output bpp_e                pix_bpp_o,
  output logic                pix_mono_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic              have_q;
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  bpp_e              bpp_q;
  logic              mono_q;

  bpp_e             bpp_c;
  logic [CNT_W-1:0] npix_m1;
  logic [4:0]       shamt;
  logic             last, take, accept;

  assign bpp_c  = (bpp_i > 3'd4) ? BPP16 : bpp_e'(bpp_i);
  assign last   = (cnt_q == '0);
  assign take   = adv_i & have_q;
  assign word_ready_o = ~have_q | (take & last);
  assign accept = word_valid_i & word_ready_o;

  always_comb begin
    unique case (bpp_c)
      BPP1:    npix_m1 = CNT_W'(WORD_W - 1);
      BPP2:    npix_m1 = CNT_W'(WORD_W / 2 - 1);
      BPP4:    npix_m1 = CNT_W'(WORD_W / 4 - 1);
      BPP8:    npix_m1 = CNT_W'(WORD_W / 8 - 1);
      default: npix_m1 = '0;
    endcase
  end

  always_comb begin
    unique case (bpp_q)
      BPP1:    shamt = 5'd1;
      BPP2:    shamt = 5'd2;
      BPP4:    shamt = 5'd4;
      BPP8:    shamt = 5'd8;
      default: shamt = 5'd16;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      bpp_q  <= BPP1;
      mono_q <= 1'b0;
    end else if (accept) begin
      have_q <= 1'b1;
      sh_q   <= word_data_i;
      cnt_q  <= npix_m1;
      bpp_q  <= bpp_c;
      mono_q <= mono_i;
    end else if (take) begin
      sh_q  <= sh_q << shamt;
      cnt_q <= cnt_q - 1'b1;
      if (last) have_q <= 1'b0;
    end
  end

  // current pixel is always the top bits of the shift register
  always_comb begin
    unique case (bpp_q)
      BPP1:    pix_idx_o = {7'b0, sh_q[WORD_W-1]};
      BPP2:    pix_idx_o = {6'b0, sh_q[WORD_W-1 -: 2]};
      BPP4:    pix_idx_o = {4'b0, sh_q[WORD_W-1 -: 4]};
      default: pix_idx_o = sh_q[WORD_W-1 -: 8];
    endcase
  end

  // 5-6-5 fields, top COMP_W bits of each
  assign pix_direct_o = {sh_q[WORD_W-1 -: COMP_W],
                         sh_q[WORD_W-6 -: COMP_W],
                         sh_q[4 -: COMP_W]};
  assign pix_valid_o  = have_q;
  assign pix_bpp_o    = bpp_q;
  assign pix_mono_o   = mono_q;

  p_hold_word_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (have_q && !(adv_i && last)) |=> have_q && $stable(bpp_q) && $stable(mono_q));
  p_drop_at_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(have_q) |-> $past(take && last));
  p_single_16_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (have_q && bpp_q == BPP16) |-> cnt_q == '0);
endmodule

// File: rtl/pix_palette.sv
module pix_palette
  import pix_lut_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned COMP_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [IDX_W-1:0]    addr_i,
  input  logic [COMP_W-1:0]   data_i,
  input  logic [7:0]          pix_idx_i,
  input  logic [3*COMP_W-1:0] pix_direct_i,
  input  bpp_e                bpp_i,
  input  logic                mono_i,
  output logic [3*COMP_W-1:0] color_o
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [IDX_W-1:0]  idx [NUM_TBL];
  logic [COMP_W-1:0] rd  [NUM_TBL];

  always_comb begin
    for (int t = 0; t < NUM_TBL; t++) idx[t] = pix_idx_i[IDX_W-1:0];
    if (bpp_i == BPP8) begin
      idx[TBL_RED] = IDX_W'(pix_idx_i[7:5]);
      idx[TBL_GRN] = IDX_W'(pix_idx_i[4:2]);
      idx[TBL_BLU] = IDX_W'(pix_idx_i[1:0]);
    end
  end

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    logic [COMP_W-1:0] ent_q [ENTRIES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int e = 0; e < ENTRIES; e++) ent_q[e] <= '0;
      end else if (we_i && sel_i == SEL_W'(t)) begin
        ent_q[addr_i] <= data_i;
      end
    end

    assign rd[t] = ent_q[idx[t]];

    p_write_lands_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && sel_i == SEL_W'(t)) |=> ent_q[$past(addr_i)] == $past(data_i));
  end

  always_comb begin
    if (bpp_i == BPP16)
      color_o = pix_direct_i;
    else if (mono_i && bpp_i != BPP8)
      color_o = {3{rd[TBL_GRAY]}};
    else
      color_o = {rd[TBL_RED], rd[TBL_GRN], rd[TBL_BLU]};
  end
endmodule

// File: rtl/pix_lut_top.sv
module pix_lut_top
  import pix_lut_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned COMP_W = 4,
  localparam int unsigned COL_W = 3 * COMP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        bpp_sel_i,
  input  logic              mono_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_data_i,
  output logic              word_ready_o,
  output logic              pix_valid_o,
  input  logic              pix_ready_i,
  output logic [COL_W-1:0]  pix_color_o,
  input  logic              tbl_we_i,
  input  logic [SEL_W-1:0]  tbl_sel_i,
  input  logic [IDX_W-1:0]  tbl_addr_i,
  input  logic [COMP_W-1:0] tbl_data_i
);
  logic             adv;
  logic             up_valid;
  logic [7:0]       up_idx;
  logic [COL_W-1:0] up_direct;
  bpp_e             up_bpp;
  logic             up_mono;
  logic [COL_W-1:0] color;
  logic             out_valid_q;
  logic [COL_W-1:0] out_color_q;

  assign adv = ~out_valid_q | pix_ready_i;

  pix_unpack #(.WORD_W(WORD_W), .COMP_W(COMP_W)) u_unpack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_valid_i (word_valid_i),
    .word_data_i  (word_data_i),
    .bpp_i        (bpp_sel_i),
    .mono_i       (mono_i),
    .word_ready_o (word_ready_o),
    .adv_i        (adv),
    .pix_valid_o  (up_valid),
    .pix_idx_o    (up_idx),
    .pix_direct_o (up_direct),
    .pix_bpp_o    (up_bpp),
    .pix_mono_o   (up_mono)
  );

  pix_palette #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_palette (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (tbl_we_i),
    .sel_i        (tbl_sel_i),
    .addr_i       (tbl_addr_i),
    .data_i       (tbl_data_i),
    .pix_idx_i    (up_idx),
    .pix_direct_i (up_direct),
    .bpp_i        (up_bpp),
    .mono_i       (up_mono),
    .color_o      (color)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_color_q <= '0;
    end else if (adv) begin
      out_valid_q <= up_valid;
      if (up_valid) out_color_q <= color;
    end
  end

  assign pix_valid_o = out_valid_q;
  assign pix_color_o = out_color_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_ready_i) |=> pix_valid_o && $stable(pix_color_o));
  p_bypass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && up_valid && up_bpp == BPP16) |=> pix_color_o == $past(up_direct));
  p_no_take_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid && !adv) |-> !word_ready_o);
endmodule

// File: tb/pix_lut_top_tb_top.sv
module pix_lut_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bpp_sel = '0;
  logic        mono = 1'b0;
  logic        word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic        word_ready;
  logic        pix_valid;
  logic        pix_ready = 1'b1;
  logic [11:0] pix_color;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_sel = '0;
  logic [3:0]  tbl_addr = '0;
  logic [3:0]  tbl_data = '0;

  always #2 clk = ~clk;

  pix_lut_top dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bpp_sel_i    (bpp_sel),
    .mono_i       (mono),
    .word_valid_i (word_valid),
    .word_data_i  (word_data),
    .word_ready_o (word_ready),
    .pix_valid_o  (pix_valid),
    .pix_ready_i  (pix_ready),
    .pix_color_o  (pix_color),
    .tbl_we_i     (tbl_we),
    .tbl_sel_i    (tbl_sel),
    .tbl_addr_i   (tbl_addr),
    .tbl_data_i   (tbl_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [11:0] exp_q[$];
  string       tag_q[$];
  logic [3:0]  sh_t [4][16];
  logic [11:0] mon_e;
  string       mon_t;

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] model(logic [15:0] p, int bpp, bit m);
    logic [3:0] i;
    i = p[3:0];
    if (bpp >= 4) return {p[15:12], p[10:7], p[4:1]};
    if (bpp == 3) return {sh_t[0][{1'b0, p[7:5]}], sh_t[1][{1'b0, p[4:2]}], sh_t[2][{2'b0, p[1:0]}]};
    if (m) return {3{sh_t[3][i]}};
    return {sh_t[0][i], sh_t[1][i], sh_t[2][i]};
  endfunction

  function automatic void push_word(logic [15:0] d, int bpp, bit m, string tag);
    int w;
    w = (bpp >= 4) ? 16 : (1 << bpp);
    for (int k = 0; k < 16 / w; k++) begin
      exp_q.push_back(model((d >> (16 - w * (k + 1))) & ((17'h1 << w) - 1), bpp, m));
      tag_q.push_back(tag);
    end
  endfunction

  // pixel monitor: one transfer per cycle with valid and ready high
  always @(negedge clk) begin
    #1;
    if (rst_n && pix_valid && pix_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R2 extra pixel", {4'h0, pix_color}, 16'h0);
      else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        check(pix_color == mon_e, mon_t, {4'h0, pix_color}, {4'h0, mon_e});
      end
    end
  end

  task automatic tbl_write(int s, int a, logic [3:0] v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = 2'(s); tbl_addr = 4'(a); tbl_data = v;
    sh_t[s][a] = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic send_word(logic [15:0] d, int bpp, bit m);
    @(negedge clk);
    word_valid = 1'b1; word_data = d; bpp_sel = 3'(bpp); mono = m;
    forever begin
      #1;
      if (word_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic queue_word(logic [15:0] d, int bpp, bit m, string tag);
    push_word(d, bpp, m, tag);
    send_word(d, bpp, m);
  endtask

  task automatic end_words();
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(pix_valid == 1'b0, "R1 valid after reset", {15'h0, pix_valid}, 16'h0);
    check(word_ready == 1'b1, "R1 ready after reset", {15'h0, word_ready}, 16'h1);
    queue_word(16'hA5C3, 0, 1'b0, "R1 cleared red/green/blue");
    queue_word(16'h39E6, 2, 1'b1, "R1 cleared gray");
    end_words();
    drain();
  endtask

  task automatic t_fill();
    for (int i = 0; i < 16; i++) begin
      tbl_write(0, i, 4'(i));
      tbl_write(1, i, ~4'(i));
      tbl_write(2, i, 4'((i * 7) & 15));
      tbl_write(3, i, 4'((i * 5 + 3) & 15));
    end
  endtask

  task automatic t_colour_low();
    queue_word(16'hB2D4, 0, 1'b0, "R2 R3 colour 1bpp");
    queue_word(16'h1B6C, 1, 1'b0, "R2 R3 colour 2bpp");
    queue_word(16'h9A3F, 2, 1'b0, "R2 R3 colour 4bpp");
    end_words();
    drain();
  endtask

  task automatic t_latency();
    queue_word(16'h5C3A, 2, 1'b0, "R8 latency data");
    end_words(); #1;
    check(pix_valid == 1'b0, "R8 not valid one edge after accept", {15'h0, pix_valid}, 16'h0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      check(pix_valid == 1'b1, "R8 back-to-back pixels", {15'h0, pix_valid}, 16'h1);
    end
    drain();
  endtask

  task automatic t_mono();
    queue_word(16'h8E31, 0, 1'b1, "R4 gray 1bpp");
    queue_word(16'hC6A5, 1, 1'b1, "R4 gray 2bpp");
    queue_word(16'h70FB, 2, 1'b1, "R4 gray 4bpp");
    queue_word(16'h3DA2, 3, 1'b1, "R4 mono ignored at 8bpp");
    queue_word(16'h9C4E, 4, 1'b1, "R4 mono ignored at 16bpp");
    end_words();
    drain();
  endtask

  task automatic t_8bpp();
    queue_word(16'hE41B, 3, 1'b0, "R5 8bpp split");
    queue_word(16'h5AC7, 3, 1'b0, "R5 8bpp split");
    queue_word(16'hFF00, 3, 1'b0, "R5 8bpp extremes");
    end_words();
    drain();
  endtask

  task automatic t_16bpp();
    queue_word(16'hF81F, 4, 1'b0, "R6 bypass magenta");
    queue_word(16'h07E0, 4, 1'b0, "R6 bypass green");
    queue_word(16'h1234, 4, 1'b0, "R6 bypass mixed");
    queue_word(16'h8421, 7, 1'b0, "R2 code 7 as 16bpp");
    end_words();
    drain();
  endtask

  task automatic t_rewrite();
    tbl_write(0, 5, 4'hA);
    queue_word(16'h5555, 2, 1'b0, "R7 new red entry");
    end_words();
    drain();
    tbl_write(0, 5, 4'h3);
    tbl_write(3, 5, 4'hC);
    queue_word(16'h5505, 2, 1'b0, "R7 red entry rewritten");
    queue_word(16'h5550, 2, 1'b1, "R7 gray entry rewritten");
    end_words();
    drain();
  endtask

  task automatic t_stall();
    logic [11:0] first;
    @(negedge clk);
    pix_ready = 1'b0;
    push_word(16'h4E71, 2, 1'b0, "R10 held word keeps 4bpp colour");
    push_word(16'hFFFF, 4, 1'b1, "R11 offered word kept");
    first = model(16'h0004, 2, 1'b0);
    send_word(16'h4E71, 2, 1'b0);
    @(negedge clk);
    word_data = 16'hFFFF; bpp_sel = 3'd4; mono = 1'b1;
    @(negedge clk); #1;
    check(pix_valid && pix_color == first, "R9 first pixel under stall", {4'h0, pix_color}, {4'h0, first});
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      check(pix_valid && pix_color == first, "R9 held under back-pressure", {4'h0, pix_color}, {4'h0, first});
      check(word_ready == 1'b0, "R11 not ready while busy", {15'h0, word_ready}, 16'h0);
    end
    @(negedge clk);
    pix_ready = 1'b1;
    forever begin
      #1;
      if (word_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    end_words();
    drain();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 16; a++) sh_t[s][a] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_colour_low();
    t_latency();
    t_mono();
    t_8bpp();
    t_16bpp();
    t_rewrite();
    t_stall();
    check(exp_q.size() == 0, "R2 missing pixels", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule